// File: doc/BRIEF.md
# Coarse Carrier Frequency Offset Estimator

This block gives a first, coarse estimate of the carrier frequency offset between a transmitter and a receiver. It watches complex baseband samples during the preamble of a packet. It multiplies each sample by the complex conjugate of the sample before it, which gives one phase-step vector per sample pair. These vectors are summed over a window whose length is a power of two, and the sum is scaled down by a shift. A single iterative CORDIC in vectoring mode then turns the summed vector into its angle. That angle is the mean phase advance per sample. Its negative is the per-sample increment word that a downstream derotator applies. With crystals at 40 ppm the offset can reach about 180 kHz, which is a small fraction of a turn per sample and well inside the range the estimator resolves.

A controller issues `start` when the preamble begins. The block takes the next valid sample as the phase reference and forms one product for each valid sample after it, until the window is full. It then runs the CORDIC, loads the new word and pulses `done`. The state machine has six states. IDLE waits. REF captures the reference sample. ACC forms and sums products. ALIGN scales the sums and applies a quarter-turn pre-rotation. ITER runs one CORDIC micro-rotation per cycle. OUT publishes the result.

The transitions are: `start` from any state leads to REF. REF goes to ACC on a valid sample. ACC goes to ALIGN on the valid sample that completes the window. ALIGN always goes to ITER. ITER goes to OUT after the last micro-rotation. OUT always goes to IDLE.

Top module: `cfo_coarse_est`

## Requirements
- R1: While reset is held and right after it, `freq_word` is 0 and `done` is 0.
- R2: After `start`, the first valid sample is used only as the reference. Each of the next 2^LOG2_WIN valid samples forms a product with the sample before it: real part = i·i_prev + q·q_prev, imaginary part = q·i_prev − i·q_prev. All of these products are summed.
- R3: Cycles with `in_valid` low inside a window leave the sums unchanged. A window delivered with idle gaps gives exactly the same word as the same samples delivered back to back.
- R4: `freq_word` is the two's complement negative of round(atan2(Σim, Σre) · 2^ANG_W / 2π), taken modulo 2^ANG_W, within ±3 LSB. This holds for phase steps in all four quadrants.
- R5: When both sums, shifted right by LOG2_WIN, are zero, the published word is exactly 0.
- R6: `done` is high for exactly one cycle. It is first seen high ITER+2 clock edges after the edge that accepts the last sample of the window.
- R7: `freq_word` changes only in the cycle `done` is high. It keeps its value through a later `start` and the whole of the next window.
- R8: A `start` that arrives while a window is in progress drops that window. The next result depends only on samples that follow the latest `start`, and the dropped window gives no `done`.
- R9: Valid samples that arrive before any `start`, or after a window is complete, have no effect. They give no `done` and do not change the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that opens a new estimation window |
| in_valid | input | 1 | Qualifies `in_i` and `in_q` |
| in_i | input | IN_W | In-phase sample, signed |
| in_q | input | IN_W | Quadrature sample, signed |
| freq_word | output | ANG_W | Per-sample correction increment, signed, 2^ANG_W per full turn |
| done | output | 1 | One-cycle pulse when a new word is loaded |

## Verification
The bench drives steps with phase in every quadrant and near ±π, where a design that mishandles the quarter-turn pre-rotation or the angle wrap would give a word off by about half a turn. It sends all-zero input, where a CORDIC fed a null vector drifts to roughly 100 degrees unless zero is detected. It resends the same samples with heavy idle gaps to catch products that include invalid data or skip the reference. It aborts windows part way to catch partial sums that leak into the next result. It also checks the exact latency to `done`, which shows an off-by-one in the window or iteration count.

// File: rtl/cfo_pkg.sv
package cfo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_ACC,
        ST_ALIGN,
        ST_ITER,
        ST_OUT
    } cfo_state_e;

    // atan(2^-k) as a fraction of a full turn, scaled to 2^32
    function automatic logic [31:0] atan_turn32(input int k);
        case (k)
            0:  return 32'd536870912;
            1:  return 32'd316933406;
            2:  return 32'd167458907;
            3:  return 32'd85004756;
            4:  return 32'd42667331;
            5:  return 32'd21354465;
            6:  return 32'd10679838;
            7:  return 32'd5340245;
            8:  return 32'd2670163;
            9:  return 32'd1335087;
            10: return 32'd667544;
            11: return 32'd333772;
            12: return 32'd166886;
            13: return 32'd83443;
            14: return 32'd41722;
            15: return 32'd20861;
            default: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/cfo_diff_prod.sv
module cfo_diff_prod #(
    parameter int IN_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           take,
    input  logic signed [IN_W-1:0]         cur_i,
    input  logic signed [IN_W-1:0]         cur_q,
    output logic signed [2*IN_W:0]         prod_re,
    output logic signed [2*IN_W:0]         prod_im
);
    localparam int PROD_W = 2 * IN_W + 1;

    logic signed [IN_W-1:0]   prv_i_q;
    logic signed [IN_W-1:0]   prv_q_q;
    logic signed [PROD_W-1:0] ci, cq, pi, pq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_i_q <= '0;
            prv_q_q <= '0;
        end else if (take) begin
            prv_i_q <= cur_i;
            prv_q_q <= cur_q;
        end
    end

    assign ci = PROD_W'(cur_i);
    assign cq = PROD_W'(cur_q);
    assign pi = PROD_W'(prv_i_q);
    assign pq = PROD_W'(prv_q_q);

    // current sample times conjugate of the stored one
    assign prod_re = ci * pi + cq * pq;
    assign prod_im = cq * pi - ci * pq;

endmodule

// File: rtl/cfo_phase_accum.sv
module cfo_phase_accum #(
    parameter int PROD_W   = 25,
    parameter int LOG2_WIN = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     add,
    input  logic signed [PROD_W-1:0] prod_re,
    input  logic signed [PROD_W-1:0] prod_im,
    output logic signed [PROD_W-1:0] avg_re,
    output logic signed [PROD_W-1:0] avg_im,
    output logic                     last
);
    localparam int ACC_W = PROD_W + LOG2_WIN;

    logic signed [ACC_W-1:0] sum_re_q;
    logic signed [ACC_W-1:0] sum_im_q;
    logic [LOG2_WIN-1:0]     cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_re_q <= '0;
            sum_im_q <= '0;
            cnt_q    <= '0;
        end else if (add) begin
            sum_re_q <= sum_re_q + ACC_W'(prod_re);
            sum_im_q <= sum_im_q + ACC_W'(prod_im);
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign last   = (cnt_q == {LOG2_WIN{1'b1}});
    // power-of-two window: the mean is a plain arithmetic shift
    assign avg_re = PROD_W'(sum_re_q >>> LOG2_WIN);
    assign avg_im = PROD_W'(sum_im_q >>> LOG2_WIN);

endmodule

// File: rtl/cfo_cordic_vec.sv
module cfo_cordic_vec #(
    parameter int VW    = 27,
    parameter int ANG_W = 16,
    parameter int ITER  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic signed [VW-1:0] x_in,
    input  logic signed [VW-1:0] y_in,
    output logic [ANG_W-1:0]     angle,
    output logic                 last
);
    localparam int IW = (ITER > 1) ? $clog2(ITER) : 1;
    localparam logic [ANG_W-1:0] QUARTER = ANG_W'(1) << (ANG_W - 2);

    logic [ANG_W-1:0]     lut [ITER];
    logic signed [VW-1:0] x_q, y_q;
    logic [ANG_W-1:0]     z_q;
    logic [IW-1:0]        idx_q;
    logic                 armed_q;

    genvar g;
    generate
        for (g = 0; g < ITER; g++) begin : g_lut
            localparam logic [31:0] A32 = cfo_pkg::atan_turn32(g);
            assign lut[g] = ANG_W'((A32 + (32'd1 << (31 - ANG_W))) >> (32 - ANG_W));
        end
    endgenerate

    assign last  = step && (idx_q == IW'(ITER - 1));
    assign angle = z_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q     <= '0;
            y_q     <= '0;
            z_q     <= '0;
            idx_q   <= '0;
            armed_q <= 1'b0;
        end else if (load) begin
            idx_q   <= '0;
            armed_q <= 1'b1;
            if (x_in[VW-1]) begin
                if (!y_in[VW-1]) begin
                    x_q <= y_in;
                    y_q <= -x_in;
                    z_q <= QUARTER;
                end else begin
                    x_q <= -y_in;
                    y_q <= x_in;
                    z_q <= ANG_W'(0) - QUARTER;
                end
            end else begin
                x_q <= x_in;
                y_q <= y_in;
                z_q <= '0;
            end
        end else if (step) begin
            if (!y_q[VW-1]) begin
                x_q <= x_q + (y_q >>> idx_q);
                y_q <= y_q - (x_q >>> idx_q);
                z_q <= z_q + lut[idx_q];
            end else begin
                x_q <= x_q - (y_q >>> idx_q);
                y_q <= y_q + (x_q >>> idx_q);
                z_q <= z_q - lut[idx_q];
            end
            idx_q <= idx_q + 1'b1;
            if (last) armed_q <= 1'b0;
        end
    end

    AST_STEP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> armed_q); // R4

endmodule

// File: rtl/cfo_coarse_est.sv
module cfo_coarse_est #(
    parameter int IN_W     = 12,
    parameter int LOG2_WIN = 6,
    parameter int ANG_W    = 16,
    parameter int ITER     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_i,
    input  logic signed [IN_W-1:0]  in_q,
    output logic signed [ANG_W-1:0] freq_word,
    output logic                    done
);
    import cfo_pkg::*;

    localparam int PROD_W = 2 * IN_W + 1;
    localparam int CW     = PROD_W + 2;

    cfo_state_e state, nxt;

    logic                     take, acc_add, acc_last;
    logic signed [PROD_W-1:0] prod_re, prod_im, avg_re, avg_im;
    logic [ANG_W-1:0]         cordic_ang;
    logic                     cordic_last;
    logic                     zero_q, done_q;
    logic signed [ANG_W-1:0]  word_q;

    assign take    = in_valid && !start && (state == ST_REF || state == ST_ACC);
    assign acc_add = in_valid && !start && (state == ST_ACC);

    cfo_diff_prod #(.IN_W(IN_W)) u_prod (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .cur_i   (in_i),
        .cur_q   (in_q),
        .prod_re (prod_re),
        .prod_im (prod_im)
    );

    cfo_phase_accum #(.PROD_W(PROD_W), .LOG2_WIN(LOG2_WIN)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .add     (acc_add),
        .prod_re (prod_re),
        .prod_im (prod_im),
        .avg_re  (avg_re),
        .avg_im  (avg_im),
        .last    (acc_last)
    );

    cfo_cordic_vec #(.VW(CW), .ANG_W(ANG_W), .ITER(ITER)) u_cordic (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == ST_ALIGN),
        .step  (state == ST_ITER),
        .x_in  (CW'(avg_re)),
        .y_in  (CW'(avg_im)),
        .angle (cordic_ang),
        .last  (cordic_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start) begin
            nxt = ST_REF;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_REF:   if (in_valid) nxt = ST_ACC;
                ST_ACC:   if (in_valid && acc_last) nxt = ST_ALIGN;
                ST_ALIGN: nxt = ST_ITER;
                ST_ITER:  if (cordic_last) nxt = ST_OUT;
                ST_OUT:   nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            done_q <= 1'b0;
            zero_q <= 1'b0;
        end else begin
            done_q <= (state == ST_OUT);
            if (state == ST_ALIGN)
                zero_q <= (avg_re == '0) && (avg_im == '0);
            if (state == ST_OUT)
                word_q <= zero_q ? '0 : $signed(ANG_W'(0) - cordic_ang);
        end
    end

    assign freq_word = word_q;
    assign done      = done_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(freq_word)); // R7
    AST_DONE_AFTER_ITER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state == ST_ITER, 2)); // R6
    AST_HOLD_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACC && !in_valid && !start) |=> ($stable(avg_re) && $stable(avg_im))); // R3

endmodule

// File: tb/tb_cfo_coarse_est.sv
`timescale 1ns/1ps
module tb_cfo_coarse_est;
    localparam int  IN_W     = 12;
    localparam int  LOG2_WIN = 6;
    localparam int  WIN      = 1 << LOG2_WIN;
    localparam int  ANG_W    = 16;
    localparam int  ITER     = 16;
    localparam real PI       = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0]  in_i = '0;
    logic signed [IN_W-1:0]  in_q = '0;
    logic signed [ANG_W-1:0] freq_word;
    logic                    done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int si [0:WIN];
    int sq [0:WIN];
    logic [ANG_W-1:0] held = '0;

    always #2.5 clk = ~clk;

    cfo_coarse_est #(.IN_W(IN_W), .LOG2_WIN(LOG2_WIN), .ANG_W(ANG_W), .ITER(ITER)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q), .freq_word(freq_word), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clip(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int rnd_noise(input int n);
        if (n == 0) return 0;
        return int'($urandom_range(2 * n)) - n;
    endfunction

    task automatic gen(input real w, input int amp, input real phi0, input int noise);
        for (int k = 0; k <= WIN; k++) begin
            si[k] = clip($rtoi($floor(amp * $cos(phi0 + k * w) + 0.5)) + rnd_noise(noise));
            sq[k] = clip($rtoi($floor(amp * $sin(phi0 + k * w) + 0.5)) + rnd_noise(noise));
        end
    endtask

    // expected correction word from the requirement formulas
    function automatic int expect_word();
        longint sre;
        longint sim;
        real    a;
        int     r;
        logic [ANG_W-1:0] t;
        sre = 0;
        sim = 0;
        for (int k = 1; k <= WIN; k++) begin
            sre += longint'(si[k]) * si[k-1] + longint'(sq[k]) * sq[k-1];
            sim += longint'(sq[k]) * si[k-1] - longint'(si[k]) * sq[k-1];
        end
        if ((sre >>> LOG2_WIN) == 0 && (sim >>> LOG2_WIN) == 0) return 0;
        a = $atan2(real'(sim), real'(sre));
        r = $rtoi($floor(a / (2.0 * PI) * (2.0 ** ANG_W) + 0.5));
        t = ANG_W'(-r);
        return int'($signed(t));
    endfunction

    function automatic bit near(input int act, input int exp);
        logic [ANG_W-1:0] d;
        int sd;
        d = ANG_W'(act - exp);
        sd = int'($signed(d));
        return (sd >= -3) && (sd <= 3);
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    // sends si/sq after a start; returns latency and resulting word
    task automatic drive_window(input int gap_pct, output int lat, output int word);
        pulse_start();
        for (int k = 0; k <= WIN; k++) begin
            while (int'($urandom_range(99)) < gap_pct) begin
                in_valid = 1'b0;
                in_i = IN_W'($urandom);
                in_q = IN_W'($urandom);
                @(negedge clk);
                check(!done, "R3", "done during gap", done, 0);
            end
            in_valid = 1'b1;
            in_i = IN_W'(si[k]);
            in_q = IN_W'(sq[k]);
            if (k < WIN) @(negedge clk);
        end
        check(freq_word == $signed(held), "R7", "word held during window", freq_word, $signed(held));
        @(posedge clk);
        @(negedge clk);
        lat = 0;
        // keep valid random samples flowing after the window (R9)
        while (!done && lat < 60) begin
            in_valid = 1'b1;
            in_i = IN_W'($urandom);
            in_q = IN_W'($urandom);
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        word = int'(freq_word);
        check(lat == ITER + 2, "R6", "latency to done", lat, ITER + 2);
        @(negedge clk);
        check(!done, "R6", "done width one cycle", done, 0);
        check(int'(freq_word) == word, "R9", "word after trailing samples", freq_word, word);
        in_valid = 1'b0;
        held = ANG_W'(word);
    endtask

    task automatic run_one(input string req, input real w, input int amp,
                           input int noise, input int gap);
        int lat;
        int word;
        int exp;
        gen(w, amp, $urandom_range(6283) / 1000.0, noise);
        exp = expect_word();
        drive_window(gap, lat, word);
        check(near(word, exp), req, "freq word", word, exp);
    endtask

    initial begin
        int lat, w1, w2, exp, seen;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        check(freq_word == 0, "R1", "word in reset", freq_word, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(freq_word == 0 && done == 1'b0, "R1", "after reset", freq_word, 0);

        // R9: valid samples with no start
        seen = 0;
        for (int c = 0; c < 100; c++) begin
            in_valid = 1'b1;
            in_i = IN_W'($urandom);
            in_q = IN_W'($urandom);
            @(negedge clk);
            if (done) seen++;
        end
        in_valid = 1'b0;
        check(seen == 0, "R9", "done without start", seen, 0);
        check(freq_word == 0, "R9", "word without start", freq_word, 0);

        // R4 directed quadrants, plus the 180 kHz-class small offset
        run_one("R4", 0.3, 1500, 0, 0);
        run_one("R4", 2.0, 1500, 0, 0);
        run_one("R4", -0.5, 1500, 0, 0);
        run_one("R4", -2.5, 1500, 0, 0);
        run_one("R4", 3.1, 1800, 0, 0);
        run_one("R2", 2.0 * PI * 0.045, 1200, 0, 0);

        // R5 zero input
        for (int k = 0; k <= WIN; k++) begin si[k] = 0; sq[k] = 0; end
        drive_window(0, lat, w1);
        check(w1 == 0, "R5", "zero energy word", w1, 0);

        // R3 gap equivalence
        gen(1.1, 1000, 0.7, 30);
        drive_window(0, lat, w1);
        drive_window(70, lat, w2);
        check(w1 == w2, "R3", "gapped equals gap-free", w2, w1);

        // R8 abort a window part way
        gen(-1.7, 1500, 0.2, 0);
        pulse_start();
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            in_valid = 1'b1;
            in_i = IN_W'(si[k]);
            in_q = IN_W'(sq[k]);
            @(negedge clk);
            if (done) seen++;
        end
        in_valid = 1'b0;
        check(seen == 0, "R8", "no done for aborted window", seen, 0);
        gen(0.8, 1400, 1.3, 0);
        exp = expect_word();
        drive_window(0, lat, w1);
        check(near(w1, exp), "R8", "result after restart", w1, exp);

        // constrained random windows
        for (int n = 0; n < 20; n++) begin
            run_one("R2", ($urandom_range(62831) / 10000.0) - PI,
                    600 + int'($urandom_range(1400)), int'($urandom_range(40)),
                    int'($urandom_range(50)));
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule